// File: doc/BRIEF.md
# Bit-Serial Half-Precision Floating-Point Multiplier

This block multiplies two half-precision floating-point numbers whose fields arrive one bit per clock, least significant bit first. Each operand uses two serial lanes. The significand lane carries the full 11-bit significand, with the leading one written out. The exponent lane carries the 5-bit biased exponent followed by the sign bit. Both lanes of both operands share one frame that is marked by a start strobe on its first bit.

The significand product is built by a linear row of single-bit cells, one cell per significand bit. Each cell keeps the operand bits that have reached its position. On every clock it adds its share of the partial products into a double-width accumulator. When the frame ends, the product is normalised by keeping its upper eleven significant bits and dropping the rest. The normalisation carry goes to the exponent path. The exponent path sums the two input exponents with a serial adder while the frame arrives. A second serial adder removes the bias and adds the normalisation carry while the result is shifted out. The result sign is the XOR of the operand signs.

The result leaves on two serial lanes with the same layout as the inputs, qualified by a valid strobe. A new operation can begin every twelve clocks.

Top module: `serial_fp_mul`

## Requirements
- R1: While the external reset is low, and after its release until the first result, out_valid, out_sig and out_exp are all 0.
- R2: A frame starts on the clock edge that samples in_start high while no frame is in progress. That edge and the next SIG_W-1 edges take significand bit i on in_sig_a/in_sig_b, least significant first. On the exponent lanes, positions 0 to EXP_W-1 carry exponent bits least significant first, and position EXP_W carries the sign.
- R3: Let P be the 2·SIG_W-bit product of the two significands, whose top bits are 1. The result significand is P[2·SIG_W-1:SIG_W] when P[2·SIG_W-1] is 1, and P[2·SIG_W-2:SIG_W-1] otherwise. The lower bits are dropped without rounding.
- R4: The result exponent equals (ea + eb − EXP_BIAS + c) mod 2^EXP_W, where c is P[2·SIG_W-1].
- R5: On the output exponent lane, position EXP_W carries sign_a XOR sign_b, and positions above EXP_W are 0.
- R6: out_valid stays high for exactly SIG_W consecutive cycles. The first result bit is visible after the (SIG_W+1)-th clock edge that follows the edge sampling the first input bit.
- R7: in_start is ignored while a frame is in progress, including the edge right after its last bit. A new frame can be accepted SIG_W+1 edges after the previous one, and each accepted frame yields exactly one result.
- R8: While out_valid is low, out_sig and out_exp are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_start | input | 1 | High on the first bit of an input frame |
| in_sig_a | input | 1 | Serial significand of operand A |
| in_sig_b | input | 1 | Serial significand of operand B |
| in_exp_a | input | 1 | Serial exponent then sign of operand A |
| in_exp_b | input | 1 | Serial exponent then sign of operand B |
| out_valid | output | 1 | High while a result frame is on the outputs |
| out_sig | output | 1 | Serial result significand, LSB first |
| out_exp | output | 1 | Serial result exponent then sign, LSB first |

## Verification
If a cell stores the wrong partial-product bit, the accumulated product is wrong. The result significand then differs within the SIG_W output cycles of that frame. A wrong pick of the normalisation carry corrupts both the significand and the exponent of the same frame, so the two lanes are compared together. Errors in the frame counter or in the handling of start strobes show up right away, as a shifted out_valid window, a valid run of the wrong length, or one result too many or too few at the end of the run.

// File: rtl/serial_fp_mul_pkg.sv
package serial_fp_mul_pkg;

  // majority of three bits: carry out of a one-bit full adder
  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/sfm_cell.sv
// One 1-bit cell of the linear significand array.
// Keeps the operand bits of its own position and supplies the two
// partial-product bits of its position for the current serial step.
module sfm_cell #(
  parameter int IDX   = 0,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [CNT_W-1:0] k,
  input  logic             a_in,
  input  logic             b_in,
  output logic             row_a,
  output logic             row_b
);

  localparam logic [CNT_W-1:0] MY_POS = CNT_W'(IDX);

  logic a_q, b_q;
  logic a_d, b_d;
  logic here, below;

  assign here  = (k == MY_POS);
  assign below = (MY_POS < k);

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    if (step && here) begin
      a_d = a_in;
      b_d = b_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  // new A bit times the B bits received so far (its own included)
  assign row_b = step & a_in & (here ? b_in : (below & b_q));
  // new B bit times the A bits received earlier
  assign row_a = step & b_in & below & a_q;

endmodule

// File: rtl/sfm_sig_array.sv
// Linear array of SIG_W one-bit cells plus the product accumulator.
module sfm_sig_array #(
  parameter int SIG_W = 11,
  parameter int CNT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic               clr,
  input  logic [CNT_W-1:0]   k,
  input  logic               a_in,
  input  logic               b_in,
  output logic [2*SIG_W-1:0] product
);

  localparam int PROD_W = 2 * SIG_W;

  logic [SIG_W-1:0]  row_a, row_b;
  logic [PROD_W-1:0] acc_q, acc_d, base;

  for (genvar g = 0; g < SIG_W; g++) begin : g_cell
    sfm_cell #(.IDX(g), .CNT_W(CNT_W)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step),
      .k     (k),
      .a_in  (a_in),
      .b_in  (b_in),
      .row_a (row_a[g]),
      .row_b (row_b[g])
    );
  end

  always_comb begin
    base  = clr ? '0 : acc_q;
    acc_d = acc_q;
    if (step) begin
      acc_d = base + (PROD_W'(row_b) << k) + (PROD_W'(row_a) << k);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign product = acc_q;

endmodule

// File: rtl/sfm_exp_unit.sv
// Exponent path: serial sum of the input exponents and the sign XOR while
// the frame arrives; serial bias removal plus normalisation carry on output.
module sfm_exp_unit
  import serial_fp_mul_pkg::*;
#(
  parameter int EXP_W    = 5,
  parameter int EXP_BIAS = 15,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [CNT_W-1:0] k,
  input  logic             ea,
  input  logic             eb,
  input  logic             load,
  input  logic             norm_c,
  input  logic             run,
  input  logic [CNT_W-1:0] ocnt,
  output logic             out_bit
);

  localparam int EI_W = $clog2(EXP_W);
  localparam int KB_I = ((1 << EXP_W) - EXP_BIAS) % (1 << EXP_W);
  localparam logic [EXP_W-1:0] NEG_BIAS = KB_I[EXP_W-1:0];
  localparam logic [CNT_W-1:0] E_END = CNT_W'(EXP_W);

  logic [EXP_W-1:0] esum_q, esum_d;
  logic             ic_q, ic_d;
  logic             sgn_q, sgn_d;
  logic [EXP_W-1:0] oe_q, oe_d;
  logic             os_q, os_d;
  logic             oc_q, oc_d;
  logic             cin;
  logic [EI_W-1:0]  ii, jj;
  logic             in_exp_pos, out_exp_pos;

  assign ii          = k[EI_W-1:0];
  assign jj          = ocnt[EI_W-1:0];
  assign in_exp_pos  = (k < E_END);
  assign out_exp_pos = (ocnt < E_END);
  assign cin         = (k == '0) ? 1'b0 : ic_q;

  // input side
  always_comb begin
    esum_d = esum_q;
    ic_d   = ic_q;
    sgn_d  = sgn_q;
    if (step && in_exp_pos) begin
      esum_d[ii] = ea ^ eb ^ cin;
      ic_d       = maj3(ea, eb, cin);
    end
    if (step && (k == E_END)) begin
      sgn_d = ea ^ eb;
    end
  end

  // output side
  always_comb begin
    oe_d = oe_q;
    os_d = os_q;
    oc_d = oc_q;
    if (load) begin
      oe_d = esum_q;
      os_d = sgn_q;
      oc_d = norm_c;
    end else if (run && out_exp_pos) begin
      oc_d = maj3(oe_q[jj], NEG_BIAS[jj], oc_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      esum_q <= '0;
      ic_q   <= 1'b0;
      sgn_q  <= 1'b0;
      oe_q   <= '0;
      os_q   <= 1'b0;
      oc_q   <= 1'b0;
    end else begin
      esum_q <= esum_d;
      ic_q   <= ic_d;
      sgn_q  <= sgn_d;
      oe_q   <= oe_d;
      os_q   <= os_d;
      oc_q   <= oc_d;
    end
  end

  always_comb begin
    if (out_exp_pos)          out_bit = oe_q[jj] ^ NEG_BIAS[jj] ^ oc_q;
    else if (ocnt == E_END)   out_bit = os_q;
    else                      out_bit = 1'b0;
  end

endmodule

// File: rtl/serial_fp_mul.sv
// Top: frame control, significand array, exponent path, output serializer.
module serial_fp_mul #(
  parameter int SIG_W    = 11,
  parameter int EXP_W    = 5,
  parameter int EXP_BIAS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_start,
  input  logic in_sig_a,
  input  logic in_sig_b,
  input  logic in_exp_a,
  input  logic in_exp_b,
  output logic out_valid,
  output logic out_sig,
  output logic out_exp
);

  localparam int PROD_W = 2 * SIG_W;
  localparam int CNT_W  = $clog2(SIG_W + 1);
  localparam logic [CNT_W-1:0] LAST_IN  = CNT_W'(SIG_W);
  localparam logic [CNT_W-1:0] LAST_OUT = CNT_W'(SIG_W - 1);

  // reset: asserted asynchronously, released after two clock edges
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  // frame control
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fin_q, fin_d;
  logic             accept, in_frame, step;
  logic [CNT_W-1:0] k;

  assign accept   = in_start & ~busy_q;
  assign in_frame = busy_q & (cnt_q < LAST_IN);
  assign step     = accept | in_frame;
  assign k        = accept ? '0 : cnt_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    fin_d  = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(1);
    end else if (in_frame) begin
      cnt_d  = cnt_q + CNT_W'(1);
    end else if (busy_q) begin
      busy_d = 1'b0;
      fin_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      fin_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      fin_q  <= fin_d;
    end
  end

  // significand product
  logic [PROD_W-1:0] product;
  sfm_sig_array #(.SIG_W(SIG_W), .CNT_W(CNT_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_sync),
    .step    (step),
    .clr     (accept),
    .k       (k),
    .a_in    (in_sig_a),
    .b_in    (in_sig_b),
    .product (product)
  );

  logic             norm_c;
  logic [SIG_W-1:0] norm_sig;
  assign norm_c   = product[PROD_W-1];
  assign norm_sig = norm_c ? product[PROD_W-1:SIG_W] : product[PROD_W-2:SIG_W-1];

  // output serializer
  logic             ov_q, ov_d;
  logic [CNT_W-1:0] ocnt_q, ocnt_d;
  logic [SIG_W-1:0] osig_q, osig_d;

  always_comb begin
    ov_d   = ov_q;
    ocnt_d = ocnt_q;
    osig_d = osig_q;
    if (fin_q) begin
      ov_d   = 1'b1;
      ocnt_d = '0;
      osig_d = norm_sig;
    end else if (ov_q) begin
      osig_d = osig_q >> 1;
      ocnt_d = ocnt_q + CNT_W'(1);
      if (ocnt_q == LAST_OUT) ov_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      ov_q   <= 1'b0;
      ocnt_q <= '0;
      osig_q <= '0;
    end else begin
      ov_q   <= ov_d;
      ocnt_q <= ocnt_d;
      osig_q <= osig_d;
    end
  end

  // exponent and sign path
  logic exp_bit;
  sfm_exp_unit #(.EXP_W(EXP_W), .EXP_BIAS(EXP_BIAS), .CNT_W(CNT_W)) u_exp (
    .clk     (clk),
    .rst_n   (rst_sync),
    .step    (step),
    .k       (k),
    .ea      (in_exp_a),
    .eb      (in_exp_b),
    .load    (fin_q),
    .norm_c  (norm_c),
    .run     (ov_q),
    .ocnt    (ocnt_q),
    .out_bit (exp_bit)
  );

  assign out_valid = ov_q;
  assign out_sig   = ov_q & osig_q[0];
  assign out_exp   = ov_q & exp_bit;

endmodule

// File: rtl/sfm_checker.sv
module sfm_checker #(
  parameter int SIG_W = 11,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_rst_n,
  input logic             accept,
  input logic             fin,
  input logic             busy,
  input logic [CNT_W-1:0] cnt,
  input logic             in_start,
  input logic             out_valid,
  input logic             out_sig,
  input logic             out_exp
);

  logic [CNT_W+1:0] age;
  logic [CNT_W:0]   run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age <= '0;
      run <= '0;
    end else begin
      if (accept)         age <= (CNT_W+2)'(1);
      else if (~&age)     age <= age + (CNT_W+2)'(1);
      if (out_valid)      run <= run + (CNT_W+1)'(1);
      else                run <= '0;
    end
  end

  always @(posedge clk) begin
    if (!ext_rst_n) begin
      AST_RESET_QUIET: assert (!out_valid && !out_sig && !out_exp); // R1
    end
  end

  AST_FIN_AGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin) |-> age == (CNT_W+2)'(SIG_W + 1)); // R6

  AST_LOAD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> out_valid); // R6

  AST_RUN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> run < (CNT_W+1)'(SIG_W)); // R6

  AST_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(run) == (CNT_W+1)'(SIG_W - 1)); // R6

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_sig && !out_exp)); // R8

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_start) |=> cnt != CNT_W'(1)); // R7

endmodule

bind serial_fp_mul sfm_checker #(.SIG_W(SIG_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync),
  .ext_rst_n (rst_n),
  .accept    (accept),
  .fin       (fin_q),
  .busy      (busy_q),
  .cnt       (cnt_q),
  .in_start  (in_start),
  .out_valid (out_valid),
  .out_sig   (out_sig),
  .out_exp   (out_exp)
);

// File: tb/serial_fp_mul_test.sv
module serial_fp_mul_test;

  localparam int CLK_PERIOD = 10;
  localparam int NF   = 11;
  localparam int NE   = 5;
  localparam int BIAS = 15;
  localparam int MAXF = 512;

  logic clk, rst_n;
  logic in_start, in_sig_a, in_sig_b, in_exp_a, in_exp_b;
  logic out_valid, out_sig, out_exp;

  serial_fp_mul uut (
    .clk(clk), .rst_n(rst_n), .in_start(in_start),
    .in_sig_a(in_sig_a), .in_sig_b(in_sig_b),
    .in_exp_a(in_exp_a), .in_exp_b(in_exp_b),
    .out_valid(out_valid), .out_sig(out_sig), .out_exp(out_exp)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nexp = 0;
  int nrx = 0;
  int pos = 0;
  logic [NF-1:0] exp_sig [MAXF];
  logic [NE-1:0] exp_e   [MAXF];
  logic          exp_s   [MAXF];
  int            st_cyc  [MAXF];
  logic [NF-1:0] got_sig;
  logic [NF-1:0] got_e;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // computes the expected result from the requirements
  task automatic expect_frame(input logic [NF-1:0] a, input logic [NF-1:0] b,
                              input logic [NE-1:0] ea, input logic [NE-1:0] eb,
                              input logic sa, input logic sb);
    logic [2*NF-1:0] p;
    int c, t;
    p = (2*NF)'(a) * (2*NF)'(b);
    c = int'(p[2*NF-1]);
    exp_sig[nexp] = (c == 1) ? p[2*NF-1:NF] : p[2*NF-2:NF-1];      // R3
    t = int'(ea) + int'(eb) - BIAS + c + 64;
    exp_e[nexp]   = NE'(t % 32);                                      // R4
    exp_s[nexp]   = sa ^ sb;                                          // R5
  endtask

  // R2 frame layout; extra >= 0 raises in_start again at that bit
  task automatic send(input logic [NF-1:0] a, input logic [NF-1:0] b,
                      input logic [NE-1:0] ea, input logic [NE-1:0] eb,
                      input logic sa, input logic sb, input int extra);
    for (int i = 0; i < NF; i++) begin
      @(negedge clk);
      if (i == 0) begin
        expect_frame(a, b, ea, eb, sa, sb);
        st_cyc[nexp] = cyc + 1;
        nexp++;
      end
      in_start = (i == 0) || (i == extra);
      in_sig_a = a[i];
      in_sig_b = b[i];
      in_exp_a = (i < NE) ? ea[i] : ((i == NE) ? sa : 1'b0);
      in_exp_b = (i < NE) ? eb[i] : ((i == NE) ? sb : 1'b0);
    end
  endtask

  task automatic idle(input int n, input logic st);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_start = st;
      in_sig_a = 1'b1; in_sig_b = 1'b1; in_exp_a = 1'b1; in_exp_b = 1'b1;
    end
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (pos == 0) begin
          check(nrx < nexp, "R7 unexpected result frame", nrx, nexp);
          if (nrx < nexp)
            check(cyc - st_cyc[nrx] == NF + 1, "R6 latency", cyc - st_cyc[nrx], NF + 1);
        end
        if (pos < NF) begin
          got_sig[pos] = out_sig;
          got_e[pos]   = out_exp;
        end
        pos++;
        if (pos > NF) check(1'b0, "R6 valid too long", pos, NF);
      end else begin
        if (out_sig || out_exp) check(1'b0, "R8 output while idle", {out_sig, out_exp}, 0);
        if (pos > 0) begin
          check(pos == NF, "R6 valid length", pos, NF);
          if (nrx < nexp) begin
            check(got_sig == exp_sig[nrx], "R3 significand", got_sig, exp_sig[nrx]);
            check(got_e[NE-1:0] == exp_e[nrx], "R4 exponent", got_e[NE-1:0], exp_e[nrx]);
            check(got_e[NE] == exp_s[nrx], "R5 sign", got_e[NE], exp_s[nrx]);
            check(got_e[NF-1:NE+1] == '0, "R5 tail zero", got_e[NF-1:NE+1], 0);
          end
          nrx++;
          pos = 0;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", nrx, nexp);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b1;
    in_start = 1'b0; in_sig_a = 1'b0; in_sig_b = 1'b0; in_exp_a = 1'b0; in_exp_b = 1'b0;
    #2 rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(!out_valid && !out_sig && !out_exp, "R1 reset outputs", {out_valid, out_sig, out_exp}, 0);
    end
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check(!out_valid && !out_sig && !out_exp, "R1 after release", {out_valid, out_sig, out_exp}, 0);
    end
    // corners: smallest significands, largest significands
    send(11'h400, 11'h400, 5'd15, 5'd15, 1'b0, 1'b0, -1);  // R3 no carry
    idle(1, 1'b0);
    send(11'h7FF, 11'h7FF, 5'd15, 5'd15, 1'b1, 1'b0, -1);  // R3 carry
    idle(1, 1'b0);
    // R4: 10 + (-2) + carry 1 = 9 unbiased
    send(11'h7FF, 11'h600, 5'd25, 5'd13, 1'b1, 1'b1, -1);
    idle(1, 1'b0);
    // R4 wrap of the serial exponent sum
    send(11'h500, 11'h500, 5'd31, 5'd31, 1'b0, 1'b1, -1);
    idle(3, 1'b0);
    // R7: start strobe mid-frame and on the edge after the last bit
    send(11'h555, 11'h6AA, 5'd3, 5'd20, 1'b1, 1'b0, 5);
    idle(1, 1'b1);
    send(11'h4F1, 11'h733, 5'd17, 5'd9, 1'b0, 1'b1, 3);
    idle(1, 1'b0);
    // sweep with varying gaps, minimum interval NF+1 included
    for (int i = 0; i < 256; i++) begin
      logic [NF-1:0] a, b;
      a = NF'(1024 + ((i * 37) % 1024));
      b = NF'(1024 + ((i * 91 + 13) % 1024));
      send(a, b, NE'((i * 7) % 32), NE'((i * 3 + 5) % 32), i[0], i[1], -1);
      idle((i % 3 == 0) ? 1 : ((i % 3 == 1) ? 2 : 5), 1'b0);
    end
    idle(40, 1'b0);
    check(nrx == nexp, "R7 one result per frame", nrx, nexp);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule